// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bus side of an I2C master. Software steers it with one-shot command strobes and watches its progress through an 8-bit state word. The engine runs the bus in a fixed order. It generates a START. It sends the first byte that software places in the transmit holding register as the address byte. It samples the acknowledge from the target. After that it either shifts further written bytes out or shifts bytes in.

In a read, every received byte lands in the receive data register. The engine then holds SCL low until software answers. An ACK command asks for another byte, and a NACK command marks the last byte. Whenever the engine waits for software, it keeps SCL low and flags this in the state word. A STOP command ends the transfer. An ABORT command drops the bus at once, without a STOP condition.

SCL is produced by a programmable divider. Both lines are driven open-drain: an output high means "pull the line low". The engine reads back the real SDA level through one input.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the state word reads 0, neither SCL nor SDA is pulled low, and the receive data register reads 0.
- R2: The state word is laid out as follows:
  - bit 0: busy, meaning the phase is not IDLE.
  - bit 1: master, meaning the engine owns the bus.
  - bit 2: transmitter, meaning master and a write transfer.
  - bit 3: nacked, meaning the last acknowledge slot sampled SDA high.
  - bit 4: bushold, meaning the engine holds SCL low and waits for software.
  - bits 7:5: the phase, with IDLE=0, WAIT=1, START=2, ADDR=3, ADDRACK=4, DATA=5, DATAACK=6. WAIT is never produced.
- R3: Each bit slot lasts 8×(div+1) clock cycles. Consecutive SCL rising edges inside a byte are therefore exactly 8×(div+1) cycles apart.
- R4: A START command is command bit 0, accepted when idle or while holding. It makes SDA fall while SCL is high, then enters phase START. The next held transmit byte goes out MSB first as the address, and its bit 0 selects read (1) or write (0).
- R5: In a write, once an acknowledged ADDRACK or DATAACK hold is reached, a byte written to the transmit register is shifted out in phase DATA. Without such a byte, the engine keeps holding.
- R6: When an acknowledge slot sees NACK, the engine sets nacked. It then sends nothing further, even if a transmit byte is written, and waits for STOP.
- R7: In a read, each received byte appears in the receive data register with phase DATA and bushold set, and the register stays stable while holding. The ACK command (bit 2) drives SDA low in the acknowledge slot, and another byte follows. The NACK command (bit 3) releases SDA and holds in DATAACK.
- R8: A STOP command (bit 1) while holding makes SDA rise while SCL is high. The state word then returns to 0.
- R9: An ABORT command (bit 5) forces IDLE in the next cycle and releases both lines, with no STOP slot.
- R10: A CLEARTX command (bit 6) discards a pending transmit byte. A following START then waits in phase START and sends no address.
- R11: A START command while holding after a byte produces a repeated START with no STOP in between. The new address byte then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd | input | 8 | Command bits (START 0, STOP 1, ACK 2, NACK 3, ABORT 5, CLEARTX 6) |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Transmit byte |
| div | input | 9 | Clock divider; bit slot is 8×(div+1) cycles |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| state | output | 8 | State word (see R2) |
| rx_data | output | 8 | Last received byte |

## Verification
A behavioural target on the open-drain bus watches the lines. It acknowledges its own address, refuses a chosen data byte, and serves a computed read pattern. The bench runs write transfers at several divider settings and checks the SCL spacing. A wrong divider would show up as a different edge interval.

Address refusal and data refusal are checked with a transmit byte written afterwards. An engine that ignored nacked would shift that byte out, and the target would count it. A read ending in NACK checks the acknowledge levels the target saw, so swapped ACK and NACK drive would show. A repeated START must raise the target's START count without a STOP. A pending byte cleared before START must not appear as an address. ABORT must leave the state word at 0 with the lines released in the very next cycle.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIVW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd,
  input  logic            tx_wr,
  input  logic [7:0]      tx_data,
  input  logic [DIVW-1:0] div,
  input  logic            sda_in,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic [7:0]      state,
  output logic [7:0]      rx_data
);

  localparam logic [2:0] P_IDLE    = 3'd0;
  localparam logic [2:0] P_START   = 3'd2;
  localparam logic [2:0] P_ADDR    = 3'd3;
  localparam logic [2:0] P_ADDRACK = 3'd4;
  localparam logic [2:0] P_DATA    = 3'd5;
  localparam logic [2:0] P_DATAACK = 3'd6;

  typedef enum logic [2:0] {K_NONE, K_START, K_XFER, K_RACK, K_STOP} kind_t;

  kind_t           kind;
  logic [2:0]      phase, q;
  logic [DIVW-1:0] dcnt;
  logic [3:0]      bitn;
  logic [7:0]      shreg, txh, rx_q;
  logic            txh_v, rd_mode, nacked, master, xmit, ack_bit, smp;
  logic            scl_lo, sda_lo;

  wire c_start  = cmd_valid & cmd[0];
  wire c_stop   = cmd_valid & cmd[1];
  wire c_ack    = cmd_valid & cmd[2];
  wire c_nack   = cmd_valid & cmd[3];
  wire c_abort  = cmd_valid & cmd[5];
  wire c_cleartx = cmd_valid & cmd[6];
  logic unused_cmd;
  assign unused_cmd = cmd[4] ^ cmd[7];

  wire tick     = (kind != K_NONE) && (dcnt == div);
  wire slot_end = tick && (q == 3'd7);
  wire hold     = master && (kind == K_NONE);
  wire ackph    = (phase == P_ADDRACK) || (phase == P_DATAACK);
  wire can_start = (kind == K_NONE) && ((phase == P_IDLE) || hold);
  wire go_tx    = hold && txh_v && ((phase == P_START) || (ackph && !nacked && !rd_mode));
  wire go_rx    = hold && ackph && !nacked && rd_mode;
  wire scl_bit  = (q < 3'd2) || (q >= 3'd6);

  always_comb begin
    case (kind)
      K_START: begin scl_lo = (master && q < 3'd2) || q >= 3'd6; sda_lo = q >= 3'd4; end
      K_XFER:  begin scl_lo = scl_bit; sda_lo = (bitn < 4'd8) && xmit && !shreg[7]; end
      K_RACK:  begin scl_lo = scl_bit; sda_lo = ack_bit; end
      K_STOP:  begin scl_lo = q < 3'd2; sda_lo = q < 3'd5; end
      default: begin scl_lo = master; sda_lo = 1'b0; end
    endcase
  end

  assign scl_oe  = scl_lo;
  assign sda_oe  = sda_lo;
  assign rx_data = rx_q;
  assign state   = {phase, hold, nacked, master & ~rd_mode, master, phase != P_IDLE};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= K_NONE; phase <= P_IDLE; q <= '0; dcnt <= '0; bitn <= '0;
      shreg <= '0; txh <= '0; rx_q <= '0; txh_v <= 1'b0; rd_mode <= 1'b0;
      nacked <= 1'b0; master <= 1'b0; xmit <= 1'b0; ack_bit <= 1'b0; smp <= 1'b0;
    end else begin
      if (tx_wr) begin txh <= tx_data; txh_v <= 1'b1; end
      if (c_cleartx) txh_v <= 1'b0;
      if (kind == K_NONE || tick) dcnt <= '0;
      else dcnt <= dcnt + 1'b1;
      if (tick) q <= q + 3'd1;
      if (tick && q == 3'd4) begin
        smp <= sda_in;
        if (kind == K_XFER && !xmit) shreg <= {shreg[6:0], sda_in};
      end
      if (c_abort) begin
        kind <= K_NONE; phase <= P_IDLE; master <= 1'b0; txh_v <= 1'b0; q <= '0;
      end else if (kind == K_NONE) begin
        q <= '0;
        if (c_start && can_start) begin
          kind <= K_START; phase <= P_START; rd_mode <= 1'b0; nacked <= 1'b0;
        end else if (c_stop && hold) begin
          kind <= K_STOP;
        end else if ((c_ack || c_nack) && hold && phase == P_DATA && rd_mode) begin
          kind <= K_RACK; ack_bit <= c_ack;
        end else if (go_tx) begin
          kind <= K_XFER; xmit <= 1'b1; bitn <= '0; shreg <= txh; txh_v <= 1'b0;
          phase <= (phase == P_START) ? P_ADDR : P_DATA;
          if (phase == P_START) rd_mode <= txh[0];
        end else if (go_rx) begin
          kind <= K_XFER; xmit <= 1'b0; bitn <= '0; phase <= P_DATA;
        end
      end else if (slot_end) begin
        case (kind)
          K_START: begin master <= 1'b1; kind <= K_NONE; end
          K_XFER: begin
            if (xmit && bitn < 4'd8) begin
              shreg <= {shreg[6:0], 1'b0}; bitn <= bitn + 4'd1;
            end else if (xmit) begin
              nacked <= smp; kind <= K_NONE;
              phase <= (phase == P_ADDR) ? P_ADDRACK : P_DATAACK;
            end else if (bitn < 4'd7) begin
              bitn <= bitn + 4'd1;
            end else begin
              rx_q <= shreg; kind <= K_NONE;
            end
          end
          K_RACK: begin nacked <= smp; phase <= P_DATAACK; kind <= K_NONE; end
          K_STOP: begin master <= 1'b0; nacked <= 1'b0; phase <= P_IDLE; kind <= K_NONE; end
          default: kind <= K_NONE;
        endcase
      end
    end
  end

  wire in_slot = (kind == K_XFER) || (kind == K_RACK);

  // R5: data on SDA never moves while SCL is released inside a bit slot
  a_r5_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && $past(in_slot) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R6: after a NACK the engine only leaves the hold on START, STOP or ABORT
  a_r6_nack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && nacked && !(cmd_valid && (cmd[0] || cmd[1] || cmd[5])))
      |=> (kind == K_NONE && phase == $past(phase)));

  // R7: received byte is stable while software decides
  a_r7_rx_stable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DATA && hold) |=> $stable(rx_data));

  // R8: end of a stop slot leaves the bus idle
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(kind) == K_STOP && kind == K_NONE) |-> (phase == P_IDLE && !master));

  // R9: abort releases everything in the next cycle
  a_r9_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd[5]) |=> (phase == P_IDLE && !scl_oe && !sda_oe));

endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, tx_wr = 1'b0;
  logic [7:0] cmd = '0, tx_data = '0;
  logic [8:0] div = '0;
  logic scl_oe, sda_oe, sda_in;
  logic [7:0] state, rx_data;

  int nchk = 0, nfail = 0, cyc = 0;

  // target model state
  logic sl_lo = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | sl_lo);
  assign sda_in = sda_line;
  int pc = 0, nw = 0, nr = 0, nack_at = 0, starts = 0, stops = 0, per = 0, lastc = 0;
  logic in_addr = 1'b0, rdm = 1'b0, acc = 1'b0, mack = 1'b0;
  logic [7:0] rxb = '0, cur = '0;
  logic [7:0] wbuf [0:15];
  logic       mlog [0:15];

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .tx_wr(tx_wr), .tx_data(tx_data), .div(div), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .state(state), .rx_data(rx_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rdpat(input int i);
    return 8'(8'h3C + i * 81);
  endfunction

  function automatic logic [7:0] wpat(input int d, input int k);
    return 8'(8'h5A + d * 19 + k * 77);
  endfunction

  always @(negedge sda_line) if (scl_line) begin starts++; pc = 0; in_addr = 1'b1; sl_lo = 1'b0; end
  always @(posedge sda_line) if (scl_line) begin stops++; pc = 0; sl_lo = 1'b0; end

  always @(posedge scl_line) begin
    pc++;
    if (pc <= 8) rxb = {rxb[6:0], sda_line};
    if (pc == 9) mack = !sda_line;
    if (pc == 3) per = cyc - lastc;
    lastc = cyc;
  end

  always @(negedge scl_line) begin
    if (pc == 8) begin
      if (in_addr) begin acc = (rxb[7:1] == SLV); rdm = rxb[0]; sl_lo = acc; end
      else if (!rdm) begin
        if (nw < 16) wbuf[nw] = rxb;
        nw++;
        sl_lo = (nw != nack_at);
      end else sl_lo = 1'b0;
    end else if (pc == 9) begin
      sl_lo = 1'b0;
      if (rdm && !in_addr && nr > 0 && nr <= 16) mlog[nr-1] = mack;
      if (rdm && ((in_addr && acc) || (!in_addr && mack))) begin
        cur = rdpat(nr); nr++; sl_lo = !cur[7];
      end
      in_addr = 1'b0;
      pc = 0;
    end else if (pc >= 1 && pc <= 7 && rdm && !in_addr) begin
      sl_lo = !cur[7-pc];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      nchk++; nfail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0; cmd = '0;
  endtask

  task automatic put_tx(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_hold(input logic [2:0] ph);
    while (state[4]) @(negedge clk);
    while (!(state[4] && state[7:5] == ph)) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (state[7:5] != 3'd0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int s0, p0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state == 8'h00, "R1 state after reset", state, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(rx_data == 8'h00, "R1 rx_data after reset", rx_data, 0);

    // R3 R4 R5 R8: write transfers over a sweep of divider values
    for (int d = 0; d < 6; d++) begin
      div = 9'(d == 5 ? 7 : d);
      nw = 0; nack_at = 0; s0 = starts; p0 = stops;
      do_cmd(8'h01);
      put_tx({SLV, 1'b0});
      wait_hold(3'd4);
      chk(state == 8'h97, "R2 R4 ADDRACK hold word", state, 8'h97);
      chk(starts == s0 + 1, "R4 start condition seen", starts, s0 + 1);
      for (int k = 0; k < 2; k++) begin
        put_tx(wpat(d, k));
        wait_hold(3'd6);
        chk(state == 8'hD7, "R5 DATAACK hold word", state, 8'hD7);
      end
      chk(per == 8 * (int'(div) + 1), "R3 SCL period", per, 8 * (int'(div) + 1));
      chk(nw == 2, "R5 byte count", nw, 2);
      chk(wbuf[0] == wpat(d, 0) && wbuf[1] == wpat(d, 1), "R5 bytes MSB first",
          {wbuf[0], wbuf[1]}, {wpat(d, 0), wpat(d, 1)});
      idle(50);
      chk(state == 8'hD7, "R5 holds without new byte", state, 8'hD7);
      do_cmd(8'h02);
      wait_idle();
      chk(state == 8'h00, "R8 idle after stop", state, 0);
      chk(stops == p0 + 1, "R8 stop condition seen", stops, p0 + 1);
      chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
    end

    // R6: address refused
    div = 9'd1; nw = 0; p0 = stops;
    do_cmd(8'h01);
    put_tx({7'h11, 1'b0});
    wait_hold(3'd4);
    chk(state == 8'h9F, "R6 nacked after address", state, 8'h9F);
    put_tx(8'hFF);
    idle(200);
    chk(state == 8'h9F, "R6 still waiting for stop", state, 8'h9F);
    chk(nw == 0, "R6 no byte sent after nack", nw, 0);
    do_cmd(8'h40);
    do_cmd(8'h02);
    wait_idle();
    chk(stops == p0 + 1 && state == 8'h00, "R6 stop ends refused transfer", state, 0);

    // R10: pending byte discarded before START
    put_tx({SLV, 1'b0});
    do_cmd(8'h40);
    s0 = starts;
    do_cmd(8'h01);
    wait_hold(3'd2);
    idle(100);
    chk(state == 8'h57, "R10 waits in START phase", state, 8'h57);
    chk(starts == s0 + 1 && pc <= 1, "R10 no address clocked", pc, 0);
    put_tx({SLV, 1'b0});
    wait_hold(3'd4);
    chk(state == 8'h97, "R10 address after fresh write", state, 8'h97);

    // R6: data byte refused
    nw = 0; nack_at = 2;
    put_tx(8'h11); wait_hold(3'd6);
    put_tx(8'h22); wait_hold(3'd6);
    chk(state == 8'hDF, "R6 nacked after data", state, 8'hDF);
    put_tx(8'h33);
    idle(200);
    chk(nw == 2, "R6 third byte withheld", nw, 2);
    do_cmd(8'h40);
    do_cmd(8'h02);
    wait_idle();
    nack_at = 0;

    // R7: read three bytes
    div = 9'd2; nr = 0;
    do_cmd(8'h01);
    put_tx({SLV, 1'b1});
    for (int k = 0; k < 3; k++) begin
      wait_hold(3'd5);
      chk(state == 8'hB3, "R7 DATA hold word", state, 8'hB3);
      chk(rx_data == rdpat(k), "R7 received byte", rx_data, rdpat(k));
      idle(40);
      chk(rx_data == rdpat(k), "R7 rx stable in hold", rx_data, rdpat(k));
      do_cmd(k < 2 ? 8'h04 : 8'h08);
    end
    wait_hold(3'd6);
    chk(state == 8'hDB, "R7 NACK sent, DATAACK hold", state, 8'hDB);
    chk(mlog[0] == 1'b1 && mlog[1] == 1'b1, "R7 ACK level seen", {mlog[0], mlog[1]}, 2'b11);
    chk(mlog[2] == 1'b0, "R7 NACK level seen", mlog[2], 0);
    chk(nr == 3, "R7 byte count", nr, 3);
    do_cmd(8'h02);
    wait_idle();

    // R11: repeated START into a read
    div = 9'd0; nw = 0; nr = 0; s0 = starts; p0 = stops;
    do_cmd(8'h01);
    put_tx({SLV, 1'b0}); wait_hold(3'd4);
    put_tx(8'hC3); wait_hold(3'd6);
    do_cmd(8'h01);
    wait_hold(3'd2);
    chk(starts == s0 + 2 && stops == p0, "R11 repeated start without stop", starts - s0, 2);
    put_tx({SLV, 1'b1});
    wait_hold(3'd5);
    chk(rx_data == rdpat(0) && wbuf[0] == 8'hC3, "R11 read after repeated start", rx_data, rdpat(0));
    do_cmd(8'h08);
    wait_hold(3'd6);
    do_cmd(8'h02);
    wait_idle();

    // R9: abort in the middle of an address byte
    div = 9'd3;
    do_cmd(8'h01);
    put_tx({SLV, 1'b0});
    idle(100);
    chk(state[7:5] == 3'd3, "R9 mid-address before abort", state[7:5], 3);
    @(negedge clk); cmd_valid = 1'b1; cmd = 8'h20;
    @(negedge clk); cmd_valid = 1'b0; cmd = '0;
    chk(state == 8'h00, "R9 idle next cycle", state, 0);
    chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    idle(300);
    chk(state == 8'h00 && !scl_oe && !sda_oe, "R9 no stop slot follows", state, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule